// File: doc/BRIEF.md
# MAC Frame Statistics Counter Bank

This block keeps twelve event counters for the transmit and receive halves of an Ethernet MAC. The transmitter and the receiver each send a one-cycle completion report when a frame is finished. A transmit frame is finished when it has fully left on the link or has been aborted. A receive frame is finished when it has fully arrived. Each report carries a status word. The block classifies that status and advances every matching counter in the cycle after the report. Nothing is counted at an intermediate point of a frame. Counters are `CNT_W` bits wide (32 by default) and stop at their all-ones value.

Software reads the counters through a command port. A dump request streams all counters out, in a fixed order, as (byte offset, value) pairs on a valid/ready channel. A dump-and-reset request streams the same words and clears each counter in the cycle its word is accepted. An event that lands on a counter in that same cycle is kept as the counter's new value, so no event is lost. A done pulse marks the last accepted word. Commands are accepted only while no dump is running.

Top module: `mstat_bank`

## Requirements
- R1: After reset every counter reads zero, `cmd_ready` is 1, and `dump_valid` and `dump_done` are 0.
- R2: An accepted command produces exactly twelve words. Their offsets are 0, 4, … 44, and they map as follows: 0 tx good, 4 max-collision abort, 8 late-collision abort, 12 underrun, 16 lost carrier, 20 deferred, 24 single collision, 28 multiple collision, 32 total collisions, 36 rx good, 40 rx CRC error, 44 rx alignment error. A word holds its offset while `dump_ready` is low. `dump_done` is 1 exactly when the word at offset 44 is accepted.
- R3: A transmit report with `tx_sent`=1 and neither abort flag set counts as tx good. Each abort flag increments its own abort counter, and the frame is then not counted as tx good.
- R4: A delivered frame with `tx_ncol`=1 increments the single-collision counter. A delivered frame with `tx_ncol`>1 increments only the multiple-collision counter. Aborted frames increment neither.
- R5: Every transmit report adds `tx_ncol` to the total-collisions counter, aborted frames included.
- R6: Every transmit report adds `tx_urun` (underrun occurrences for that frame) to the underrun counter, so one frame can add more than one.
- R7: The lost-carrier counter increments only for delivered frames with `tx_crs_lost`=1. The deferred counter increments for any report with `tx_defer`=1.
- R8: Receive error classes are exclusive. With `rx_short`=1 neither the CRC nor the alignment counter moves. A bad CRC with `rx_misalign`=1 counts only as an alignment error. A bad CRC with `rx_misalign`=0 counts only as a CRC error.
- R9: Rx good increments only for reports with `rx_stored`=1, `rx_short`=0 and `rx_crc_bad`=0. The CRC and alignment counters update whatever `rx_stored` is.
- R10: Dump-and-reset (`cmd_clear`=1) leaves every counter at zero. A plain dump (`cmd_clear`=0) leaves all values unchanged.
- R11: When an event hits a counter in the cycle that counter's word is accepted during dump-and-reset, the word shows the old value and the counter then holds the new event's increment.
- R12: A counter that would pass its maximum holds all ones instead of wrapping.
- R13: While a dump runs, `cmd_ready` is 0 and any command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | 1 | Transmit frame completion report strobe |
| tx_sent | input | 1 | Frame left on the link |
| tx_abort_maxcol | input | 1 | Frame aborted at the maximum collision count |
| tx_abort_late | input | 1 | Frame aborted by a collision after the slot time |
| tx_defer | input | 1 | Frame was held off by link activity |
| tx_crs_lost | input | 1 | Carrier dropped during transmission |
| tx_ncol | input | NCOL_W | Collisions seen over all attempts |
| tx_urun | input | URUN_W | Underrun occurrences for this frame |
| rx_done | input | 1 | Receive frame completion report strobe |
| rx_stored | input | 1 | Whole frame stored |
| rx_short | input | 1 | Frame shorter than minimum |
| rx_crc_bad | input | 1 | CRC check failed |
| rx_misalign | input | 1 | Carrier ended off an octet boundary |
| cmd_valid | input | 1 | Command request |
| cmd_clear | input | 1 | 1 = dump-and-reset, 0 = dump |
| cmd_ready | output | 1 | Command can be accepted (no dump running) |
| dump_valid | output | 1 | Dump word valid |
| dump_ready | input | 1 | Dump word consumer ready |
| dump_offset | output | OFS_W | Byte offset of the current word |
| dump_value | output | CNT_W | Counter value of the current word |
| dump_done | output | 1 | Last word accepted |

## Verification
A wrong classification shows up as a counter value that is off in the next dump of that counter. Its offset tells which rule failed. The monitor compares each accepted word to the model as it leaves the block, so a fault is reported within one dump. A broken sequencer, with a skipped index, an offset that moves while stalled, or a late done, is flagged at the very word where it occurs. A clear that drops or duplicates an event only appears one dump later, so every dump-and-reset is followed by a further dump.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

   localparam int NUM_CNT = 12;

   localparam int IX_TX_GOOD  = 0;
   localparam int IX_MAXCOL   = 1;
   localparam int IX_LATE     = 2;
   localparam int IX_URUN     = 3;
   localparam int IX_CRS      = 4;
   localparam int IX_DEFER    = 5;
   localparam int IX_SINGLE   = 6;
   localparam int IX_MULTI    = 7;
   localparam int IX_TOTAL    = 8;
   localparam int IX_RX_GOOD  = 9;
   localparam int IX_RX_CRC   = 10;
   localparam int IX_RX_ALIGN = 11;

   localparam int NUM_TX = 9;
   localparam int NUM_RX = 3;

   typedef enum logic {
      MODE_KEEP  = 1'b0,
      MODE_CLEAR = 1'b1
   } dump_mode_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/mstat_tx_class.sv
module mstat_tx_class #(
   parameter int NCOL_W = 5,
   parameter int URUN_W = 4,
   parameter int INC_W  = 5
) (
   input  logic              done,
   input  logic              sent,
   input  logic              abort_maxcol,
   input  logic              abort_late,
   input  logic              defer,
   input  logic              crs_lost,
   input  logic [NCOL_W-1:0] ncol,
   input  logic [URUN_W-1:0] urun,
   output logic [INC_W-1:0]  inc_good,
   output logic [INC_W-1:0]  inc_maxcol,
   output logic [INC_W-1:0]  inc_late,
   output logic [INC_W-1:0]  inc_urun,
   output logic [INC_W-1:0]  inc_crs,
   output logic [INC_W-1:0]  inc_defer,
   output logic [INC_W-1:0]  inc_single,
   output logic [INC_W-1:0]  inc_multi,
   output logic [INC_W-1:0]  inc_total
);

   localparam logic [INC_W-1:0] ONE = INC_W'(1);

   logic aborted;
   logic delivered;
   logic one_col;
   logic many_col;

   always_comb begin
      aborted   = abort_maxcol | abort_late;
      delivered = done & sent & ~aborted;
      one_col   = (ncol == NCOL_W'(1));
      many_col  = (ncol > NCOL_W'(1));

      inc_good   = delivered ? ONE : '0;
      inc_maxcol = (done & abort_maxcol) ? ONE : '0;
      inc_late   = (done & abort_late) ? ONE : '0;
      inc_crs    = (delivered & crs_lost) ? ONE : '0;
      inc_defer  = (done & defer) ? ONE : '0;
      inc_single = (delivered & one_col) ? ONE : '0;
      inc_multi  = (delivered & many_col) ? ONE : '0;
      inc_total  = done ? INC_W'(ncol) : '0;
      inc_urun   = done ? INC_W'(urun) : '0;
   end

endmodule

// File: rtl/mstat_rx_class.sv
module mstat_rx_class #(
   parameter int INC_W = 5
) (
   input  logic             done,
   input  logic             stored,
   input  logic             short_err,
   input  logic             crc_bad,
   input  logic             misalign,
   output logic [INC_W-1:0] inc_good,
   output logic [INC_W-1:0] inc_crc,
   output logic [INC_W-1:0] inc_align
);

   localparam logic [INC_W-1:0] ONE = INC_W'(1);

   logic sized_ok;
   logic err_align;
   logic err_crc;
   logic good;

   always_comb begin
      sized_ok  = done & ~short_err;
      err_align = sized_ok & crc_bad & misalign;
      err_crc   = sized_ok & crc_bad & ~misalign;
      good      = sized_ok & stored & ~crc_bad;

      inc_good  = good ? ONE : '0;
      inc_crc   = err_crc ? ONE : '0;
      inc_align = err_align ? ONE : '0;
   end

endmodule

// File: rtl/mstat_cntr.sv
module mstat_cntr #(
   parameter int CNT_W    = 32,
   parameter int INC_W    = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] q
);

   logic [CNT_W-1:0] base;
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      base = clr ? '0 : q;
      sum  = {1'b0, base} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb nxt = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      end else begin : g_wrap
         always_comb nxt = sum[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/mstat_dump_seq.sv
module mstat_dump_seq
   import mstat_pkg::*;
#(
   parameter int NUM   = 12,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_clear,
   output logic             cmd_ready,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [IDX_W-1:0] idx,
   output logic             out_done,
   output logic [NUM-1:0]   clr_vec
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM - 1);

   seq_state_e       state_q;
   dump_mode_e       mode_q;
   logic [IDX_W-1:0] idx_q;
   logic             fire;
   logic             last;

   always_comb begin
      cmd_ready = (state_q == SEQ_IDLE);
      out_valid = (state_q == SEQ_RUN);
      fire      = out_valid & out_ready;
      last      = (idx_q == LAST_IDX);
      out_done  = fire & last;
      idx       = idx_q;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM; gi++) begin : g_clr
         assign clr_vec[gi] = fire & (mode_q == MODE_CLEAR) & (idx_q == IDX_W'(gi));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         mode_q  <= MODE_KEEP;
         idx_q   <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (cmd_valid) begin
                  state_q <= SEQ_RUN;
                  mode_q  <= cmd_clear ? MODE_CLEAR : MODE_KEEP;
                  idx_q   <= '0;
               end
            end
            default: begin
               if (fire) begin
                  if (last) begin
                     state_q <= SEQ_IDLE;
                     idx_q   <= '0;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/mstat_bank.sv
module mstat_bank
   import mstat_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int NCOL_W   = 5,
   parameter int URUN_W   = 4,
   parameter int OFS_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_done,
   input  logic              tx_sent,
   input  logic              tx_abort_maxcol,
   input  logic              tx_abort_late,
   input  logic              tx_defer,
   input  logic              tx_crs_lost,
   input  logic [NCOL_W-1:0] tx_ncol,
   input  logic [URUN_W-1:0] tx_urun,
   input  logic              rx_done,
   input  logic              rx_stored,
   input  logic              rx_short,
   input  logic              rx_crc_bad,
   input  logic              rx_misalign,
   input  logic              cmd_valid,
   input  logic              cmd_clear,
   output logic              cmd_ready,
   output logic              dump_valid,
   input  logic              dump_ready,
   output logic [OFS_W-1:0]  dump_offset,
   output logic [CNT_W-1:0]  dump_value,
   output logic              dump_done
);

   localparam int INC_W = (NCOL_W > URUN_W) ? NCOL_W : URUN_W;
   localparam int IDX_W = $clog2(NUM_CNT);

   generate
      if (CNT_W <= INC_W) begin : g_bad_cnt_w
         $error("mstat_bank: CNT_W must exceed the increment width");
      end
      if (OFS_W < IDX_W + 2) begin : g_bad_ofs_w
         $error("mstat_bank: OFS_W too narrow for the last byte offset");
      end
      if (NCOL_W < 1 || URUN_W < 1) begin : g_bad_fields
         $error("mstat_bank: status field widths must be at least 1");
      end
   endgenerate

   logic [INC_W-1:0] inc_a [NUM_CNT];
   logic [CNT_W-1:0] cnt_q [NUM_CNT];
   logic [NUM_CNT-1:0] clr_vec;
   logic [IDX_W-1:0]   idx;

   mstat_tx_class #(
      .NCOL_W(NCOL_W),
      .URUN_W(URUN_W),
      .INC_W (INC_W)
   ) u_tx (
      .done        (tx_done),
      .sent        (tx_sent),
      .abort_maxcol(tx_abort_maxcol),
      .abort_late  (tx_abort_late),
      .defer       (tx_defer),
      .crs_lost    (tx_crs_lost),
      .ncol        (tx_ncol),
      .urun        (tx_urun),
      .inc_good    (inc_a[IX_TX_GOOD]),
      .inc_maxcol  (inc_a[IX_MAXCOL]),
      .inc_late    (inc_a[IX_LATE]),
      .inc_urun    (inc_a[IX_URUN]),
      .inc_crs     (inc_a[IX_CRS]),
      .inc_defer   (inc_a[IX_DEFER]),
      .inc_single  (inc_a[IX_SINGLE]),
      .inc_multi   (inc_a[IX_MULTI]),
      .inc_total   (inc_a[IX_TOTAL])
   );

   mstat_rx_class #(
      .INC_W(INC_W)
   ) u_rx (
      .done     (rx_done),
      .stored   (rx_stored),
      .short_err(rx_short),
      .crc_bad  (rx_crc_bad),
      .misalign (rx_misalign),
      .inc_good (inc_a[IX_RX_GOOD]),
      .inc_crc  (inc_a[IX_RX_CRC]),
      .inc_align(inc_a[IX_RX_ALIGN])
   );

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CNT; gc++) begin : g_cnt
         mstat_cntr #(
            .CNT_W   (CNT_W),
            .INC_W   (INC_W),
            .SATURATE(SATURATE)
         ) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_vec[gc]),
            .inc  (inc_a[gc]),
            .q    (cnt_q[gc])
         );
      end
   endgenerate

   mstat_dump_seq #(
      .NUM  (NUM_CNT),
      .IDX_W(IDX_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_clear(cmd_clear),
      .cmd_ready(cmd_ready),
      .out_valid(dump_valid),
      .out_ready(dump_ready),
      .idx      (idx),
      .out_done (dump_done),
      .clr_vec  (clr_vec)
   );

   always_comb begin
      dump_offset = {{(OFS_W - IDX_W - 2){1'b0}}, idx, 2'b00};
      dump_value  = cnt_q[idx];
   end

endmodule

// File: rtl/mstat_bank_chk.sv
module mstat_bank_chk #(
   parameter int OFS_W = 8,
   parameter int INC_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic             dump_valid,
   input logic             dump_ready,
   input logic [OFS_W-1:0] dump_offset,
   input logic             dump_done,
   input logic             tx_abort_maxcol,
   input logic             tx_abort_late,
   input logic [INC_W-1:0] inc_single,
   input logic [INC_W-1:0] inc_multi,
   input logic [INC_W-1:0] inc_crc,
   input logic [INC_W-1:0] inc_align
);

   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (dump_valid && dump_offset == '0)); // R2

   AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dump_valid && dump_ready && !dump_done) |=>
         (dump_valid && dump_offset == OFS_W'($past(dump_offset) + OFS_W'(4)))); // R2

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dump_valid && !dump_ready) |=> (dump_valid && $stable(dump_offset))); // R2

   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      dump_done |=> !dump_valid); // R2

   AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      dump_valid |-> !cmd_ready); // R13

   AST_COL_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({inc_single != '0, inc_multi != '0})); // R4

   AST_ABORT_NO_COL_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_abort_maxcol || tx_abort_late) |-> (inc_single == '0 && inc_multi == '0)); // R4

   AST_RX_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({inc_crc != '0, inc_align != '0})); // R8

endmodule

bind mstat_bank mstat_bank_chk #(
   .OFS_W(OFS_W),
   .INC_W(INC_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_valid      (cmd_valid),
   .cmd_ready      (cmd_ready),
   .dump_valid     (dump_valid),
   .dump_ready     (dump_ready),
   .dump_offset    (dump_offset),
   .dump_done      (dump_done),
   .tx_abort_maxcol(tx_abort_maxcol),
   .tx_abort_late  (tx_abort_late),
   .inc_single     (inc_a[mstat_pkg::IX_SINGLE]),
   .inc_multi      (inc_a[mstat_pkg::IX_MULTI]),
   .inc_crc        (inc_a[mstat_pkg::IX_RX_CRC]),
   .inc_align      (inc_a[mstat_pkg::IX_RX_ALIGN])
);

// File: tb/mstat_bank_test.sv
module mstat_bank_test;

   localparam int CLK_NS = 10;
   localparam int CW     = 8;
   localparam int NC     = 12;
   localparam longint MAXV = (64'd1 << CW) - 1;

   typedef struct packed {
      logic [7:0]    ofs;
      logic [CW-1:0] val;
      logic          last;
      logic [7:0]    req;
   } sb_item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_done = 0, tx_sent = 0, tx_abort_maxcol = 0, tx_abort_late = 0;
   logic          tx_defer = 0, tx_crs_lost = 0;
   logic [4:0]    tx_ncol = '0;
   logic [3:0]    tx_urun = '0;
   logic          rx_done = 0, rx_stored = 0, rx_short = 0, rx_crc_bad = 0, rx_misalign = 0;
   logic          cmd_valid = 0, cmd_clear = 0;
   logic          cmd_ready;
   logic          dump_valid;
   logic          dump_ready = 0;
   logic [7:0]    dump_offset;
   logic [CW-1:0] dump_value;
   logic          dump_done;

   int     n_chk = 0;
   int     n_bad = 0;
   bit     finished = 0;
   longint mdl [NC];
   sb_item_t sb_q [$];

   always #(CLK_NS / 2) clk = ~clk;

   mstat_bank #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n),
      .tx_done(tx_done), .tx_sent(tx_sent), .tx_abort_maxcol(tx_abort_maxcol),
      .tx_abort_late(tx_abort_late), .tx_defer(tx_defer), .tx_crs_lost(tx_crs_lost),
      .tx_ncol(tx_ncol), .tx_urun(tx_urun),
      .rx_done(rx_done), .rx_stored(rx_stored), .rx_short(rx_short),
      .rx_crc_bad(rx_crc_bad), .rx_misalign(rx_misalign),
      .cmd_valid(cmd_valid), .cmd_clear(cmd_clear), .cmd_ready(cmd_ready),
      .dump_valid(dump_valid), .dump_ready(dump_ready), .dump_offset(dump_offset),
      .dump_value(dump_value), .dump_done(dump_done)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic void madd(input int ix, input longint v);
      mdl[ix] = (mdl[ix] + v > MAXV) ? MAXV : mdl[ix] + v;
   endfunction

   // monitor: compares every accepted dump word with the queued expectation
   always @(negedge clk) begin
      if (rst_n && dump_valid && dump_ready) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R2 unexpected word", longint'(dump_offset), -1);
         end else begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(dump_offset == it.ofs && dump_value == it.val && dump_done == it.last,
                  $sformatf("R%0d word ofs=%0d done=%0b", it.req, dump_offset, dump_done),
                  longint'(dump_value), longint'(it.val));
         end
      end
   end

   // driver: queue expected words, issue a command, drain with optional stalls
   task automatic push_snapshot(input int req);
      for (int i = 0; i < NC; i++) begin
         sb_item_t it;
         it.ofs  = 8'(i * 4);
         it.val  = CW'(mdl[i]);
         it.last = (i == NC - 1);
         it.req  = 8'(req);
         sb_q.push_back(it);
      end
   endtask

   task automatic drain(input bit stall, input bit poke);
      int c = 0;
      while (sb_q.size() != 0) begin
         dump_ready = stall ? (c % 3 != 1) : 1'b1;
         if (poke && c == 2) begin
            check(cmd_ready == 1'b0, "R13 cmd_ready while busy", cmd_ready, 0);
            cmd_valid = 1'b1;
            cmd_clear = 1'b1;
         end
         if (poke && c == 4) cmd_valid = 1'b0;
         c++;
         tick();
      end
      dump_ready = 1'b0;
      tick();
      check(dump_valid == 1'b0, "R2 stream ends after 12 words", dump_valid, 0);
   endtask

   task automatic do_dump(input bit clr, input int req, input bit stall, input bit poke);
      push_snapshot(req);
      if (clr) for (int i = 0; i < NC; i++) mdl[i] = 0;
      cmd_valid = 1'b1;
      cmd_clear = clr;
      tick();
      cmd_valid = 1'b0;
      cmd_clear = 1'b0;
      drain(stall, poke);
   endtask

   task automatic send_tx(input bit sent, input bit mc, input bit lt, input bit df,
                          input bit cl, input int ncol, input int urun);
      bit del;
      tx_sent = sent; tx_abort_maxcol = mc; tx_abort_late = lt;
      tx_defer = df; tx_crs_lost = cl; tx_ncol = 5'(ncol); tx_urun = 4'(urun);
      tx_done = 1'b1;
      tick();
      tx_done = 1'b0;
      del = sent && !mc && !lt;
      madd(0, del);
      madd(1, mc);
      madd(2, lt);
      madd(3, urun);
      madd(4, del && cl);
      madd(5, df);
      madd(6, del && ncol == 1);
      madd(7, del && ncol > 1);
      madd(8, ncol);
   endtask

   task automatic send_rx(input bit st, input bit sh, input bit crc, input bit mis);
      rx_stored = st; rx_short = sh; rx_crc_bad = crc; rx_misalign = mis;
      rx_done = 1'b1;
      tick();
      rx_done = 1'b0;
      madd(9, st && !sh && !crc);
      madd(10, !sh && crc && !mis);
      madd(11, !sh && crc && mis);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NC; i++) mdl[i] = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: idle state after reset, all counters zero
      check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
      check(dump_valid == 1'b0, "R1 dump_valid", dump_valid, 0);
      check(dump_done == 1'b0, "R1 dump_done", dump_done, 0);
      do_dump(1'b0, 1, 1'b0, 1'b0);

      // R3 R4 R5 R6 R7: transmit classification
      send_tx(1, 0, 0, 0, 0, 0, 0);
      send_tx(1, 0, 0, 0, 0, 0, 0);
      send_tx(1, 0, 0, 0, 0, 1, 0);
      send_tx(1, 0, 0, 1, 0, 3, 0);
      send_tx(0, 1, 0, 0, 0, 16, 0);
      send_tx(0, 0, 1, 0, 0, 2, 0);
      send_tx(1, 0, 0, 0, 1, 0, 0);
      send_tx(0, 0, 1, 0, 1, 1, 0);
      send_tx(1, 0, 0, 0, 0, 0, 3);
      send_tx(0, 0, 0, 1, 0, 0, 2);
      do_dump(1'b0, 3, 1'b0, 1'b0);

      // R8 R9: receive classification, stalled drain exercises R2 hold
      send_rx(1, 0, 0, 0);
      send_rx(1, 1, 1, 0);
      send_rx(1, 0, 1, 1);
      send_rx(1, 0, 1, 0);
      send_rx(0, 0, 1, 0);
      send_rx(0, 0, 1, 1);
      send_rx(1, 0, 0, 1);
      send_rx(0, 0, 0, 0);
      do_dump(1'b0, 8, 1'b1, 1'b0);

      // R10: plain dump kept values (checked above by repeat); now clear and recheck
      do_dump(1'b0, 10, 1'b0, 1'b0);
      do_dump(1'b1, 10, 1'b1, 1'b0);
      do_dump(1'b0, 10, 1'b0, 1'b0);

      // R11: event lands on tx good in the cycle its word is cleared
      send_tx(1, 0, 0, 0, 0, 0, 0);
      send_tx(1, 0, 0, 0, 0, 0, 0);
      push_snapshot(11);
      for (int i = 0; i < NC; i++) mdl[i] = 0;
      cmd_valid = 1'b1;
      cmd_clear = 1'b1;
      dump_ready = 1'b1;
      tick();
      cmd_valid = 1'b0;
      cmd_clear = 1'b0;
      tx_sent = 1; tx_abort_maxcol = 0; tx_abort_late = 0; tx_defer = 0;
      tx_crs_lost = 0; tx_ncol = '0; tx_urun = '0;
      tx_done = 1'b1;
      tick();
      tx_done = 1'b0;
      mdl[0] = 1;
      drain(1'b0, 1'b0);
      do_dump(1'b0, 11, 1'b0, 1'b0);

      // R13: dump-and-reset request during a running dump is ignored
      send_rx(1, 0, 1, 0);
      do_dump(1'b0, 13, 1'b1, 1'b1);
      check(dump_valid == 1'b0, "R13 no extra dump", dump_valid, 0);
      do_dump(1'b0, 13, 1'b0, 1'b0);

      // R12: saturation of total collisions and underrun
      for (int k = 0; k < 9; k++) send_tx(0, 1, 0, 0, 0, 31, 15);
      for (int k = 0; k < 10; k++) send_tx(0, 0, 0, 0, 0, 31, 15);
      do_dump(1'b0, 12, 1'b0, 1'b0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule